// File: doc/BRIEF.md
# Conversion Pacing Clock Generator

This block paces the main converters of a multi-channel acquisition front end. It picks one of several candidate clock sources: a fast reference, a slower reference, or one of four shared synchronisation lines. It divides the chosen source by a programmable value plus one. Each resulting pulse is a conversion start. Each converter averages eight conversions into one result, so a second fixed divide-by-eight produces a sample-ready strobe at the output sample rate.

Every candidate source arrives as a one-cycle edge enable in the single system clock domain. The block never switches clocks; it only counts enables.

Conversion starts must never exceed 1 MHz. The divider is therefore raised to a floor on the two reference sources: 65 on the fast source and 23 on the slow one. A configuration error flag goes up whenever the divider is raised or the source code is unknown. Any change to the source code or to the divider restarts both counters, so the next selected edge begins a fresh period.

Top module: `conv_pacer`

## Requirements
- R1: With divider value N, `conv_strobe` pulses once for every N+1 enables of the selected source. Each pulse is one system clock wide and appears in the cycle after the enable that completes the count.
- R2: A divider value of 0 passes the selected source straight through: every selected enable produces one `conv_strobe`.
- R3: `sample_strobe` pulses on every eighth `conv_strobe` since the last restart, in the same cycle as that conversion strobe, and never without one.
- R4: Source codes on `src_sel` select the source as follows:
  - 5'h00 selects `fast_clk_en`.
  - 5'h10 selects `slow_clk_en`.
  - 5'h08, 5'h09, 5'h0A and 5'h0B select `sync_en[0]` to `sync_en[3]`.
  Enables on sources that are not selected have no effect on either strobe.
- R5: With the fast source selected (5'h00), a divider below 65 is treated as 65 and `cfg_err` is high. At 65 or above, `cfg_err` is low.
- R6: With the slow source selected (5'h10), a divider below 23 is treated as 23 and `cfg_err` is high. At 23 or above, `cfg_err` is low.
- R7: With a sync line selected, any divider from 0 to 1023 is used as given and `cfg_err` is low.
- R8: A source code outside the six listed selects no source. Neither strobe fires, and `cfg_err` is high.
- R9: A change of `src_sel` or `div_val` clears both counters. No `conv_strobe` follows in the next cycle, and counting restarts from the next selected enable.
- R10: While `rst_n` is low, both strobes are low. After reset with a legal configuration, `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 5 | Clock-source select code |
| div_val | input | 10 | Divider value N (rate = source / (N+1)) |
| fast_clk_en | input | 1 | Edge enable of the fast reference source |
| slow_clk_en | input | 1 | Edge enable of the slow reference source |
| sync_en | input | 4 | Edge enables of the four sync lines |
| conv_strobe | output | 1 | Conversion-start strobe, one cycle wide |
| sample_strobe | output | 1 | Sample-ready strobe, every eighth conversion |
| cfg_err | output | 1 | Divider was raised to a floor, or source code unknown |

## Verification
The bound checker watches four properties on every cycle:
- a sample strobe never fires without a conversion strobe;
- no conversion strobe follows a configuration change;
- every conversion strobe is preceded by some source enable;
- the error flag matches the legality of a stable source code.

The exact division ratios, the floors on the two reference sources, the insensitivity to unselected lines and the restart phase all need counted bursts of enables. Only the bench scenarios can show those: they count strobes over known numbers of source edges and compare against figures derived from the requirements.

// File: rtl/conv_pacer_pkg.sv
// Shared constants for the conversion pacing generator: select codes,
// divider floors and the source classification used between submodules.
package conv_pacer_pkg;
    localparam int          SEL_W         = 5;
    localparam logic [4:0]  SEL_FAST      = 5'h00;
    localparam logic [4:0]  SEL_SLOW      = 5'h10;
    localparam logic [4:0]  SEL_SYNC_BASE = 5'h08;
    localparam int          FAST_MIN_DIV  = 65;
    localparam int          SLOW_MIN_DIV  = 23;
    localparam int          RESET_DIV     = 65;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_SYNC = 2'd2,
        SRC_NONE = 2'd3
    } src_kind_e;
endpackage

// File: rtl/conv_src_select.sv
// Source selector: decodes the sparse select code and forwards the enable
// of the chosen source. Assumes every enable is already synchronous to clk.
module conv_src_select
    import conv_pacer_pkg::*;
#(
    parameter int SYNC_N = 4
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              fast_en,
    input  logic              slow_en,
    input  logic [SYNC_N-1:0] sync_en,
    output logic              tick,
    output src_kind_e         kind
);
    logic [SYNC_N-1:0] sync_hit;

    // one decoder per sync line
    for (genvar i = 0; i < SYNC_N; i++) begin : g_sync_dec
        assign sync_hit[i] = (sel == SEL_SYNC_BASE + SEL_W'(i));
    end

    // classify the code and pick the matching enable
    always_comb begin
        if (sel == SEL_FAST) begin
            kind = SRC_FAST;
            tick = fast_en;
        end else if (sel == SEL_SLOW) begin
            kind = SRC_SLOW;
            tick = slow_en;
        end else if (|sync_hit) begin
            kind = SRC_SYNC;
            tick = |(sync_hit & sync_en);
        end else begin
            kind = SRC_NONE;
            tick = 1'b0;
        end
    end
endmodule

// File: rtl/conv_div_limit.sv
// Divider limiter: raises the programmed divider to the floor that keeps
// conversions at or under the converter's rate limit; flags illegal setups.
module conv_div_limit
    import conv_pacer_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  src_kind_e         kind,
    input  logic [DIV_W-1:0]  div_in,
    output logic [DIV_W-1:0]  div_eff,
    output logic              err
);
    localparam logic [DIV_W-1:0] FAST_FLOOR = DIV_W'(FAST_MIN_DIV);
    localparam logic [DIV_W-1:0] SLOW_FLOOR = DIV_W'(SLOW_MIN_DIV);

    // apply the per-source floor
    always_comb begin
        div_eff = div_in;
        err     = 1'b0;
        case (kind)
            SRC_FAST: if (div_in < FAST_FLOOR) begin
                div_eff = FAST_FLOOR;
                err     = 1'b1;
            end
            SRC_SLOW: if (div_in < SLOW_FLOOR) begin
                div_eff = SLOW_FLOOR;
                err     = 1'b1;
            end
            SRC_NONE: err = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/conv_edge_counter.sv
// Modulo counter of input ticks: wrap is high (combinationally) on the tick
// that completes term+1 ticks. clear has priority and swallows any tick.
module conv_edge_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] term,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = tick && !clear && (cnt_q == term);

    // advance or restart the count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/conv_pacer.sv
// Conversion pacing generator top: source select, clamped divide-by-(N+1),
// then a fixed divide by 2**AVG_LOG2 for the sample-ready strobe.
// Assumes enables are one-cycle pulses in the clk domain; outputs are registered.
module conv_pacer
    import conv_pacer_pkg::*;
#(
    parameter int SYNC_N   = 4,
    parameter int DIV_W    = 10,
    parameter int AVG_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        src_sel,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              fast_clk_en,
    input  logic              slow_clk_en,
    input  logic [SYNC_N-1:0] sync_en,
    output logic              conv_strobe,
    output logic              sample_strobe,
    output logic              cfg_err
);
    localparam logic [AVG_LOG2-1:0] AVG_TERM = '1;

    logic [4:0]       sel_q;
    logic [DIV_W-1:0] div_q;
    logic             cfg_change;
    logic             tick;
    src_kind_e        kind;
    logic [DIV_W-1:0] div_eff;
    logic             conv_wrap;
    logic             avg_wrap;

    assign cfg_change = (src_sel != sel_q) || (div_val != div_q);

    // hold the configuration to detect writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_FAST;
            div_q <= DIV_W'(RESET_DIV);
        end else begin
            sel_q <= src_sel;
            div_q <= div_val;
        end
    end

    conv_src_select #(.SYNC_N(SYNC_N)) sel_i (
        .sel     (sel_q),
        .fast_en (fast_clk_en),
        .slow_en (slow_clk_en),
        .sync_en (sync_en),
        .tick    (tick),
        .kind    (kind)
    );

    conv_div_limit #(.DIV_W(DIV_W)) lim_i (
        .kind    (kind),
        .div_in  (div_q),
        .div_eff (div_eff),
        .err     (cfg_err)
    );

    conv_edge_counter #(.W(DIV_W)) conv_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_change),
        .tick  (tick),
        .term  (div_eff),
        .wrap  (conv_wrap)
    );

    conv_edge_counter #(.W(AVG_LOG2)) avg_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_change),
        .tick  (conv_wrap),
        .term  (AVG_TERM),
        .wrap  (avg_wrap)
    );

    // register the strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_strobe   <= 1'b0;
            sample_strobe <= 1'b0;
        end else begin
            conv_strobe   <= conv_wrap;
            sample_strobe <= conv_wrap && avg_wrap;
        end
    end
endmodule

// File: rtl/conv_pacer_chk.sv
// Port-level checker for conv_pacer, attached by bind.
module conv_pacer_chk #(
    parameter int SYNC_N = 4,
    parameter int DIV_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        src_sel,
    input logic [DIV_W-1:0]  div_val,
    input logic              fast_clk_en,
    input logic              slow_clk_en,
    input logic [SYNC_N-1:0] sync_en,
    input logic              conv_strobe,
    input logic              sample_strobe,
    input logic              cfg_err
);
    logic any_en;
    logic sel_known;
    assign any_en    = fast_clk_en || slow_clk_en || (|sync_en);
    assign sel_known = (src_sel == 5'h00) || (src_sel == 5'h10) ||
                       ((src_sel >= 5'h08) && (src_sel < 5'h08 + 5'(SYNC_N)));

    assert_sample_with_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> conv_strobe);

    assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(src_sel) || !$stable(div_val)) |=> !conv_strobe);

    assert_strobe_has_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> $past(any_en));

    assert_unknown_sel_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(src_sel) && !sel_known) |-> cfg_err);

    assert_sync_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(src_sel) && src_sel >= 5'h08 && src_sel < 5'h08 + 5'(SYNC_N)) |-> !cfg_err);
endmodule

bind conv_pacer conv_pacer_chk #(.SYNC_N(SYNC_N), .DIV_W(DIV_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_sel       (src_sel),
    .div_val       (div_val),
    .fast_clk_en   (fast_clk_en),
    .slow_clk_en   (slow_clk_en),
    .sync_en       (sync_en),
    .conv_strobe   (conv_strobe),
    .sample_strobe (sample_strobe),
    .cfg_err       (cfg_err)
);

// File: tb/conv_pacer_tb_top.sv
module conv_pacer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_sel = 5'h00;
    logic [9:0] div_val = 10'd65;
    logic       fast_clk_en = 1'b0;
    logic       slow_clk_en = 1'b0;
    logic [3:0] sync_en = 4'h0;
    logic       conv_strobe, sample_strobe, cfg_err;

    int checks = 0;
    int errors = 0;
    int conv_total = 0;
    int samp_total = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    conv_pacer dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_val(div_val),
        .fast_clk_en(fast_clk_en), .slow_clk_en(slow_clk_en), .sync_en(sync_en),
        .conv_strobe(conv_strobe), .sample_strobe(sample_strobe), .cfg_err(cfg_err)
    );

    // strobe tallies, sampled away from the active edge
    always @(negedge clk) begin
        if (conv_strobe)   conv_total++;
        if (sample_strobe) samp_total++;
    end

    // lanes: [0] fast, [1] slow, [5:2] sync0..3
    typedef struct packed {
        logic [4:0]  sel;
        logic [9:0]  div;
        logic [5:0]  lanes;
        logic [11:0] k;
        logic [7:0]  conv;
        logic [3:0]  samp;
        logic        err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'h00, 10'd65,   6'b000001, 12'd528,  8'd8,  4'd1, 1'b0}, // R1 R4 R5 fast legal
        '{5'h00, 10'd10,   6'b000001, 12'd528,  8'd8,  4'd1, 1'b1}, // R5 clamp to 65
        '{5'h10, 10'd23,   6'b000010, 12'd480,  8'd20, 4'd2, 1'b0}, // R6 slow legal
        '{5'h10, 10'd5,    6'b000010, 12'd480,  8'd20, 4'd2, 1'b1}, // R6 clamp to 23
        '{5'h08, 10'd0,    6'b000100, 12'd40,   8'd40, 4'd5, 1'b0}, // R2 R7 pass-through
        '{5'h0B, 10'd2,    6'b100000, 12'd100,  8'd33, 4'd4, 1'b0}, // R1 R3 R7 sync3
        '{5'h09, 10'd1023, 6'b001000, 12'd2048, 8'd2,  4'd0, 1'b0}, // R1 R7 max divider
        '{5'h05, 10'd7,    6'b111111, 12'd50,   8'd0,  4'd0, 1'b1}, // R8 unknown code
        '{5'h0A, 10'd7,    6'b010001, 12'd64,   8'd8,  4'd1, 1'b0}, // R4 sync2 plus noise
        '{5'h0A, 10'd7,    6'b000001, 12'd64,   8'd0,  4'd0, 1'b0}  // R4 unselected ignored
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [5:0] lanes);
        @(negedge clk);
        fast_clk_en = lanes[0];
        slow_clk_en = lanes[1];
        sync_en     = lanes[5:2];
        @(negedge clk);
        fast_clk_en = 1'b0;
        slow_clk_en = 1'b0;
        sync_en     = 4'h0;
    endtask

    task automatic configure(input logic [4:0] s, input logic [9:0] d);
        @(negedge clk);
        src_sel = s;
        div_val = d;
        repeat (3) @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        int c0, s0;
        repeat (4) @(negedge clk);
        // R10 strobes low in reset
        check("R10 conv in reset", int'(conv_strobe), 0);
        check("R10 sample in reset", int'(sample_strobe), 0);
        rst_n = 1'b1;
        settle();
        check("R10 err after reset", int'(cfg_err), 0);

        for (int v = 0; v < NV; v++) begin
            configure(VECS[v].sel, VECS[v].div);
            check($sformatf("R5 R6 R7 R8 err vec%0d", v), int'(cfg_err), int'(VECS[v].err));
            c0 = conv_total;
            s0 = samp_total;
            for (int t = 0; t < int'(VECS[v].k); t++) pulse(VECS[v].lanes);
            settle();
            check($sformatf("R1 R2 R4 conv count vec%0d", v), conv_total - c0, int'(VECS[v].conv));
            check($sformatf("R3 sample count vec%0d", v), samp_total - s0, int'(VECS[v].samp));
        end

        // R9 conversion counter restart
        configure(5'h08, 10'd3);
        c0 = conv_total;
        pulse(6'b000100);
        pulse(6'b000100);
        configure(5'h08, 10'd4);
        for (int t = 0; t < 4; t++) pulse(6'b000100);
        settle();
        check("R9 no strobe before new period", conv_total - c0, 0);
        pulse(6'b000100);
        settle();
        check("R9 strobe at fifth edge after restart", conv_total - c0, 1);

        // R9 averaging counter restart, R3 coincidence with conversion
        configure(5'h08, 10'd0);
        for (int t = 0; t < 5; t++) pulse(6'b000100);
        configure(5'h09, 10'd0);
        s0 = samp_total;
        for (int t = 0; t < 7; t++) pulse(6'b001000);
        settle();
        check("R9 sample count restarted", samp_total - s0, 0);
        @(negedge clk);
        fast_clk_en = 1'b0;
        sync_en = 4'b0010;
        @(negedge clk);
        sync_en = 4'h0;
        check("R3 sample strobe on eighth", int'(sample_strobe), 1);
        check("R3 conv coincident", int'(conv_strobe), 1);

        // R10 reset mid-run
        configure(5'h08, 10'd0);
        @(negedge clk);
        sync_en = 4'b0001;
        rst_n = 1'b0;
        @(negedge clk);
        sync_en = 4'h0;
        check("R10 no strobe under reset", int'(conv_strobe), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule